// File: doc/BRIEF.md
# Static Memory Bus Controller

This block connects a simple internal request port to an external parallel bus with an 8-bit data path. The bus can serve static memories or parallel peripherals. A request gives an address, a size (byte, halfword or word), a direction and write data, under a valid/ready handshake. The top address bits pick one of four chip selects. Each chip select covers a 16-Mbyte window and is addressed by the low 24 bits.

A halfword or word request is split into consecutive byte cycles at incrementing addresses, least significant byte first. Every byte cycle has three phases: setup, strobe pulse and hold. Each chip select holds six timing fields, a setup, pulse and hold count for reads and another three for writes, loaded through a small register write port. For a read, the bytes are gathered into one value, zero-extended to 32 bits, and returned when the handshake completes.

Top module: `static_bus_ctrl`

## Requirements
- R1: After reset all chip selects and both strobes are inactive (high), bus_doe and req_ready are low, and every timing field is zero.
- R2: req_addr[25:24] selects the chip select, and only that bus_cs_n bit goes low (active low) during the transfer. bus_addr is req_addr[23:0] plus the byte index. At most one chip select is low at any time.
- R3: req_size 0 is a byte (1 cycle), 1 is a halfword (2 cycles), and 2 or 3 is a word (4 cycles). The byte cycles run at incrementing addresses, least significant byte first.
- R4: In a read byte cycle, the chip select is low with both strobes high for the read setup count, then bus_rd_n is low for the read pulse count, then the hold count elapses with bus_rd_n high.
- R5: A write uses the write setup, pulse and hold counts of its chip select, with bus_wr_n as the strobe. The read counts have no effect on a write.
- R6: A setup or hold count of zero removes that phase. A pulse count of zero acts as one clock.
- R7: During a write, bus_doe is high and bus_dout carries the current byte from the start of setup through the end of hold.
- R8: Read data is sampled from bus_din on the last clock of each pulse. rsp_rdata holds the reassembled value, zero-extended, while req_ready is high.
- R9: req_ready is high for exactly one cycle, with all chip selects inactive, in the cycle after the last hold. Counted from the first clock after acceptance, it arrives in clock bytes*(setup+pulse+hold)+1.
- R10: When cfg_we is high, cfg_data loads the timing fields of the select given by cfg_sel. The layout is [3:0] read setup, [7:4] read pulse, [11:8] read hold, [15:12] write setup, [19:16] write pulse, [23:20] write hold.
- R11: bus_rd_n and bus_wr_n are never low together, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_ready | output | 1 | One-cycle completion of the request |
| req_addr | input | 26 | Select bits [25:24], window offset [23:0] |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, low byte first on the bus |
| rsp_rdata | output | 32 | Reassembled read data, valid with req_ready |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Chip select whose timing is written |
| cfg_data | input | 24 | Six 4-bit timing fields |
| bus_addr | output | 24 | External byte address |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 8 | Write data byte |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 8 | Read data byte |

## Verification
The read-data sample on the last pulse clock can land in the same cycle as the advance to the next byte. When both setup and hold are zero, the address and the expected input byte change on the very next clock while the strobe stays low. This case is provoked with halfword and word reads whose read setup and hold are zero. The bench's memory model drives bus_din from the current address, so a sample taken one clock late or early would gather the wrong byte. The result is judged by comparing the reassembled word with what an earlier write stored, and by the cycle and strobe counts of the transfer.

// File: rtl/static_bus_ctrl.sv
module static_bus_ctrl #(
  parameter int NUM_CS = 4,
  parameter int CS_ADDR_W = 24,
  parameter int CNT_W = 4,
  localparam int CS_W = $clog2(NUM_CS),
  localparam int ADDR_W = CS_ADDR_W + CS_W,
  localparam int CFG_W = 6 * CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  input  logic                 cfg_we,
  input  logic [CS_W-1:0]      cfg_sel,
  input  logic [CFG_W-1:0]     cfg_data,
  output logic [CS_ADDR_W-1:0] bus_addr,
  output logic [NUM_CS-1:0]    bus_cs_n,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [7:0]           bus_dout,
  output logic                 bus_doe,
  input  logic [7:0]           bus_din
);
  typedef enum logic [2:0] {IDLE, SETUP, PULSE, HOLD, DONE} st_t;

  st_t st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [1:0] idx, idx_n, last_idx;
  logic [CS_ADDR_W-1:0] addr_q;
  logic [CS_W-1:0] cs_q, sel_cs;
  logic [1:0] size_q;
  logic wr_q, sel_wr, adv, sample;
  logic [31:0] wdata_q, rdata_q;

  logic [CNT_W-1:0] rs [NUM_CS];
  logic [CNT_W-1:0] rp [NUM_CS];
  logic [CNT_W-1:0] rh [NUM_CS];
  logic [CNT_W-1:0] ws [NUM_CS];
  logic [CNT_W-1:0] wp [NUM_CS];
  logic [CNT_W-1:0] wh [NUM_CS];
  logic [CNT_W-1:0] t_s, t_p, t_pe, t_h;
  st_t first_st;
  logic [CNT_W-1:0] first_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        rs[i] <= '0; rp[i] <= '0; rh[i] <= '0;
        ws[i] <= '0; wp[i] <= '0; wh[i] <= '0;
      end
    end else if (cfg_we) begin
      rs[cfg_sel] <= cfg_data[0*CNT_W +: CNT_W];
      rp[cfg_sel] <= cfg_data[1*CNT_W +: CNT_W];
      rh[cfg_sel] <= cfg_data[2*CNT_W +: CNT_W];
      ws[cfg_sel] <= cfg_data[3*CNT_W +: CNT_W];
      wp[cfg_sel] <= cfg_data[4*CNT_W +: CNT_W];
      wh[cfg_sel] <= cfg_data[5*CNT_W +: CNT_W];
    end
  end

  assign sel_cs = (st == IDLE) ? req_addr[ADDR_W-1 -: CS_W] : cs_q;
  assign sel_wr = (st == IDLE) ? req_write : wr_q;
  assign t_s  = sel_wr ? ws[sel_cs] : rs[sel_cs];
  assign t_p  = sel_wr ? wp[sel_cs] : rp[sel_cs];
  assign t_h  = sel_wr ? wh[sel_cs] : rh[sel_cs];
  assign t_pe = (t_p == '0) ? CNT_W'(1) : t_p;
  assign first_st  = (t_s != '0) ? SETUP : PULSE;
  assign first_cnt = (t_s != '0) ? t_s - 1'b1 : t_pe - 1'b1;
  assign last_idx  = (size_q == 2'd0) ? 2'd0 : (size_q == 2'd1) ? 2'd1 : 2'd3;

  always_comb begin
    st_n = st;
    cnt_n = cnt;
    idx_n = idx;
    adv = 1'b0;
    sample = 1'b0;
    case (st)
      IDLE: if (req_valid) begin
        st_n = first_st;
        cnt_n = first_cnt;
        idx_n = 2'd0;
      end
      SETUP: if (cnt == '0) begin
        st_n = PULSE;
        cnt_n = t_pe - 1'b1;
      end else cnt_n = cnt - 1'b1;
      PULSE: if (cnt == '0) begin
        sample = !wr_q;
        if (t_h != '0) begin
          st_n = HOLD;
          cnt_n = t_h - 1'b1;
        end else adv = 1'b1;
      end else cnt_n = cnt - 1'b1;
      HOLD: if (cnt == '0) adv = 1'b1;
            else cnt_n = cnt - 1'b1;
      DONE: st_n = IDLE;
      default: st_n = IDLE;
    endcase
    if (adv) begin
      if (idx == last_idx) st_n = DONE;
      else begin
        idx_n = idx + 2'd1;
        st_n = first_st;
        cnt_n = first_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      idx <= '0;
      addr_q <= '0;
      cs_q <= '0;
      size_q <= '0;
      wr_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st <= st_n;
      cnt <= cnt_n;
      idx <= idx_n;
      if (st == IDLE && req_valid) begin
        addr_q <= req_addr[CS_ADDR_W-1:0];
        cs_q <= req_addr[ADDR_W-1 -: CS_W];
        size_q <= req_size;
        wr_q <= req_write;
        wdata_q <= req_wdata;
        rdata_q <= '0;
      end
      if (sample) rdata_q[{idx, 3'b000} +: 8] <= bus_din;
    end
  end

  logic active;
  assign active    = (st == SETUP) || (st == PULSE) || (st == HOLD);
  assign bus_cs_n  = active ? ~(NUM_CS'(1) << cs_q) : '1;
  assign bus_rd_n  = !((st == PULSE) && !wr_q);
  assign bus_wr_n  = !((st == PULSE) && wr_q);
  assign bus_doe   = active && wr_q;
  assign bus_addr  = addr_q + CS_ADDR_W'(idx);
  assign bus_dout  = 8'(wdata_q >> {idx, 3'b000});
  assign req_ready = (st == DONE);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/static_bus_ctrl_chk.sv
module static_bus_ctrl_chk #(
  parameter int NUM_CS = 4,
  parameter int CS_ADDR_W = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic [CS_ADDR_W-1:0] bus_addr,
  input logic [NUM_CS-1:0]    bus_cs_n,
  input logic                 bus_rd_n,
  input logic                 bus_wr_n,
  input logic [7:0]           bus_dout,
  input logic                 bus_doe
);
  // R11
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  // R2
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  // R11
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (~bus_cs_n != '0));
  // R9
  ready_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n));
  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_doe);
  // R7
  wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n) && $stable(bus_addr)) |-> $stable(bus_dout));
endmodule

bind static_bus_ctrl static_bus_ctrl_chk #(.NUM_CS(NUM_CS), .CS_ADDR_W(CS_ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_addr(bus_addr),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_dout(bus_dout), .bus_doe(bus_doe)
);

// File: tb/static_bus_ctrl_tb.sv
`timescale 1ns/1ps
module static_bus_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, cfg_we = 1'b0;
  logic [25:0] req_addr = '0;
  logic [1:0] req_size = '0, cfg_sel = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic [23:0] cfg_data = '0, bus_addr;
  logic [3:0] bus_cs_n;
  logic bus_rd_n, bus_wr_n, bus_doe;
  logic [7:0] bus_dout, bus_din;

  always #5 clk = ~clk;

  static_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int n_chk = 0, n_bad = 0;
  localparam logic [15:0] UPPER = 16'h5A3C;

  logic [7:0] mem [1024];
  logic [1:0] cidx;
  always_comb begin
    cidx = 2'd0;
    for (int i = 0; i < 4; i++) if (!bus_cs_n[i]) cidx = 2'(i);
  end
  assign bus_din = mem[{cidx, bus_addr[7:0]}];
  always @(negedge clk) if (!bus_wr_n) mem[{cidx, bus_addr[7:0]}] <= bus_dout;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [23:0] d);
    cfg_sel = sel; cfg_data = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int lat, strb, setup_seen, bad_sel, bad_doe;
  logic [31:0] rd_val;

  task automatic do_req(input logic [1:0] cs, input logic [1:0] sz, input logic wr,
                        input logic [7:0] a, input logic [31:0] wd);
    logic seen;
    seen = 1'b0;
    lat = 0; strb = 0; setup_seen = 0; bad_sel = 0; bad_doe = 0;
    req_addr = {cs, UPPER, a}; req_size = sz; req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      lat++;
      if (req_ready) begin
        rd_val = rsp_rdata;
        break;
      end
      if (wr && bus_cs_n != 4'hF && !bus_doe) bad_doe++;
      if (!bus_rd_n || !bus_wr_n) begin
        strb++;
        seen = 1'b1;
        if (bus_cs_n != ~(4'b1 << cs) || bus_addr[23:8] != UPPER) bad_sel++;
      end else if (bus_cs_n != 4'hF && !seen) setup_seen++;
    end
    req_valid = 1'b0;
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // {cs, size, addr, wdata, timing{wh,wp,ws,rh,rp,rs}}
  localparam logic [67:0] VEC [6] = '{
    {2'd0, 2'd0, 8'h20, 32'hFFFFFFA5, 24'h121231},
    {2'd1, 2'd1, 8'h40, 32'h1234BEEF, 24'h030000},
    {2'd2, 2'd2, 8'h80, 32'hDEADBEEF, 24'h200102},
    {2'd3, 2'd3, 8'hC0, 32'h12345678, 24'hF1F0F0},
    {2'd0, 2'd1, 8'h31, 32'h7777CAFE, 24'h000000},
    {2'd1, 2'd2, 8'hF4, 32'h89ABCDEF, 24'h111111}
  };

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cs_n", {28'd0, bus_cs_n}, 32'hF);
    check("R1", "strobes", {30'd0, bus_rd_n, bus_wr_n}, 32'h3);
    check("R1", "doe/ready", {30'd0, bus_doe, req_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6 timing fields zero after reset: one-clock pulse, no setup/hold
    do_req(2'd2, 2'd0, 1'b0, 8'h05, 32'h0);
    check("R1", "reset timing latency", lat, 2);
    check("R6", "reset timing strobe clocks", strb, 1);
    check("R8", "reset timing read byte", rd_val, {24'd0, mem[{2'd2, 8'h05}]});
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] cs, sz;
      logic [7:0] a;
      logic [31:0] wd, msk;
      logic [23:0] t;
      int nb, s, p, h;
      {cs, sz, a, wd, t} = VEC[v];
      nb = nbytes(sz);
      msk = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFFFFFF;
      cfg_write(cs, t);
      // R10 R5 R7 write phases
      do_req(cs, sz, 1'b1, a, wd);
      s = int'(t[15:12]); p = int'(t[19:16]); h = int'(t[23:20]);
      if (p == 0) p = 1;
      check("R9", $sformatf("v%0d write latency", v), lat, nb * (s + p + h) + 1);
      check("R5", $sformatf("v%0d write strobe clocks", v), strb, nb * p);
      check("R6", $sformatf("v%0d write setup clocks", v), setup_seen, s);
      check("R7", $sformatf("v%0d write drive", v), bad_doe, 0);
      check("R2", $sformatf("v%0d write select", v), bad_sel, 0);
      @(negedge clk);
      // R4 R8 read phases and reassembly
      do_req(cs, sz, 1'b0, a, 32'h0);
      s = int'(t[3:0]); p = int'(t[7:4]); h = int'(t[11:8]);
      if (p == 0) p = 1;
      check("R9", $sformatf("v%0d read latency", v), lat, nb * (s + p + h) + 1);
      check("R4", $sformatf("v%0d read strobe clocks", v), strb, nb * p);
      check("R4", $sformatf("v%0d read setup clocks", v), setup_seen, s);
      check("R2", $sformatf("v%0d read select", v), bad_sel, 0);
      check("R8", $sformatf("v%0d read data", v), rd_val, wd & msk);
      @(negedge clk);
    end

    // R3 byte order: word written, then read back one byte at a time
    cfg_write(2'd1, 24'h000000);
    do_req(2'd1, 2'd2, 1'b1, 8'h10, 32'h11223344);
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      logic [7:0] expb;
      expb = 8'(32'h11223344 >> (8 * b));
      do_req(2'd1, 2'd0, 1'b0, 8'(8'h10 + b), 32'h0);
      check("R3", $sformatf("byte %0d order", b), rd_val, {24'd0, expb});
      @(negedge clk);
    end
    // R3 size 3 acts as a word
    do_req(2'd1, 2'd3, 1'b0, 8'h10, 32'h0);
    check("R3", "size3 word", rd_val, 32'h11223344);
    check("R3", "size3 strobe clocks", strb, 4);
    @(negedge clk);

    // R5 read fields ignored by a write: large read counts, zero write counts
    cfg_write(2'd3, 24'h000FFF);
    do_req(2'd3, 2'd0, 1'b1, 8'h02, 32'h0000009C);
    check("R5", "write ignores read timing latency", lat, 2);
    @(negedge clk);
    check("R5", "write stored", {24'd0, mem[{2'd3, 8'h02}]}, 32'h9C);
    check("R11", "bus idle after", {28'd0, bus_cs_n}, 32'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule